// File: doc/BRIEF.md
# Special-Purpose Register Write Unit

This block executes the move-to-special-purpose-register instruction of a 32-bit fixed-width instruction set. Each cycle in which `valid_i` is high it examines the instruction word, reassembles the special register number from its transposed encoding, and either commits the 64-bit source operand into one of the registers it holds or classifies the request as discarded, trapped or unknown. It holds the integer exception register (XER), the link register, the count register, the vector save mask and a 64-bit time base. The register file, fetch and the unpacking of XER into flag bits live elsewhere: the block only reports the source register index so the file can be read, and it keeps XER as a 32-bit word.

A group of kernel and diagnostic numbers, together with both time-base halves, may only be written from supervisor mode. In problem state such a write raises a one-cycle privilege trap and nothing is committed. In supervisor mode the kernel and diagnostic writes are accepted and dropped. Any other number that has no target raises a one-cycle unknown-register pulse. Every recognised instruction that does not trap produces a one-cycle program-counter advance pulse, meaning an advance of 4 bytes. The instruction touches no condition bits.

Top module: `spr_write_unit`

## Requirements
- R1: An instruction is recognised only when `insn_i[31:26]` equals 31 and `insn_i[10:1]` equals 467; any other word with `valid_i` high changes no register and raises no pulse, and `insn_i[0]` is ignored.
- R2: With field F = `insn_i[20:11]`, the register number is N = {F[4:0], F[9:5]}, and `rs_idx_o` always equals `insn_i[25:21]`.
- R3: N = 1 loads `xer_o` with the low 32 bits of `src_i`; N = 8 loads `lr_o` with all 64 bits of `src_i`.
- R4: N = 9 loads `ctr_o` with the low 32 bits of `src_i`, zero-extended so that `ctr_o[63:32]` stays 0; N = 256 loads `vrsave_o` with the low 32 bits of `src_i`.
- R5: N = 284 replaces `tbase_o[31:0]` with `src_i[31:0]` and keeps bits 63:32; N = 285 replaces `tbase_o[63:32]` with `src_i[31:0]` and keeps bits 31:0.
- R6: For N in {284, 285, 272, 273, 274, 275, 1008, 1009, 18, 19} with `sup_i` low, `priv_trap_o` pulses, no register changes and `pc_adv_o` stays low.
- R7: For N in {272, 273, 274, 275, 1008, 1009, 18, 19} with `sup_i` high, no register changes, `pc_adv_o` pulses and neither `priv_trap_o` nor `unimpl_o` is raised.
- R8: Any other N raises `unimpl_o` together with `pc_adv_o`, and no register changes.
- R9: Register updates and the pulses `pc_adv_o`, `priv_trap_o`, `unimpl_o` appear on the clock edge that samples `valid_i` high, last exactly one cycle, and without `valid_i` nothing changes.
- R10: A synchronous reset `rst` clears every held register and every pulse to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction word is present this cycle |
| insn_i | input | 32 | Instruction word |
| src_i | input | 64 | Value of the source general-purpose register |
| sup_i | input | 1 | High in supervisor mode, low in problem state |
| rs_idx_o | output | 5 | Source register index for the register file |
| xer_o | output | 32 | Integer exception register |
| lr_o | output | 64 | Link register |
| ctr_o | output | 64 | Count register, upper half always zero |
| vrsave_o | output | 32 | Vector save mask |
| tbase_o | output | 64 | Time base |
| pc_adv_o | output | 1 | Pulse: advance the program counter by 4 |
| priv_trap_o | output | 1 | Pulse: privilege trap, nothing committed |
| unimpl_o | output | 1 | Pulse: unknown register number |

## Verification
The assertions assume `src_i`, `sup_i` and `insn_i` are known (not X) whenever `valid_i` is high, and that at most one instruction arrives per cycle, since each one is judged on the edge that samples it. The bench drives every input from the falling edge, holds `valid_i` for exactly one cycle per instruction and leaves an idle cycle after each, so every pulse can be seen both rising and falling. It sweeps all 1024 values of the register field in both privilege modes, which covers every number that hits a target, every privileged number and every unknown number.

// File: rtl/spr_wr_pkg.sv
package spr_wr_pkg;

   // Instruction word encoding
   localparam int unsigned OPC_PRIMARY = 31;
   localparam int unsigned OPC_EXT     = 467;

   // Logical register numbers
   localparam int unsigned N_XER    = 1;
   localparam int unsigned N_LR     = 8;
   localparam int unsigned N_CTR    = 9;
   localparam int unsigned N_VRSAVE = 256;
   localparam int unsigned N_TB_LO  = 284;
   localparam int unsigned N_TB_HI  = 285;
   localparam int unsigned N_SCR0   = 272;
   localparam int unsigned N_SCR3   = 275;
   localparam int unsigned N_CFG0   = 1008;
   localparam int unsigned N_CFG1   = 1009;
   localparam int unsigned N_FADDR  = 19;
   localparam int unsigned N_FCAUSE = 18;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_XER,
      TGT_LR,
      TGT_CTR,
      TGT_VRSAVE,
      TGT_TB_LO,
      TGT_TB_HI,
      TGT_SINK
   } spr_tgt_e;

   function automatic spr_tgt_e classify(input logic [9:0] n);
      spr_tgt_e t;
      t = TGT_NONE;
      if (n == 10'(N_XER))                                  t = TGT_XER;
      else if (n == 10'(N_LR))                              t = TGT_LR;
      else if (n == 10'(N_CTR))                             t = TGT_CTR;
      else if (n == 10'(N_VRSAVE))                          t = TGT_VRSAVE;
      else if (n == 10'(N_TB_LO))                           t = TGT_TB_LO;
      else if (n == 10'(N_TB_HI))                           t = TGT_TB_HI;
      else if (n >= 10'(N_SCR0) && n <= 10'(N_SCR3))        t = TGT_SINK;
      else if (n == 10'(N_CFG0) || n == 10'(N_CFG1))        t = TGT_SINK;
      else if (n == 10'(N_FADDR) || n == 10'(N_FCAUSE))     t = TGT_SINK;
      return t;
   endfunction

   function automatic logic needs_supervisor(input spr_tgt_e t);
      return (t == TGT_TB_LO) || (t == TGT_TB_HI) || (t == TGT_SINK);
   endfunction

endpackage

// File: rtl/spr_hold_reg.sv
module spr_hold_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (W == 0) begin : g_bad_w
         $error("spr_hold_reg: W must be non-zero");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (we) q <= d;
   end

endmodule

// File: rtl/spr_timebase.sv
module spr_timebase #(
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we_lo,
   input  logic              we_hi,
   input  logic [DATA_W-1:0] src,
   output logic [DATA_W-1:0] tb
);

   localparam int unsigned HALF_W = DATA_W / 2;

   generate
      if (DATA_W % 2 != 0) begin : g_bad_w
         $error("spr_timebase: DATA_W must be even");
      end
   endgenerate

   logic [HALF_W-1:0] lo_q, hi_q;

   // Both halves take the low half of the source; each keeps its own value
   // when the other one is written.
   spr_hold_reg #(.W(HALF_W)) u_lo (
      .clk(clk), .rst(rst), .we(we_lo), .d(src[HALF_W-1:0]), .q(lo_q)
   );

   spr_hold_reg #(.W(HALF_W)) u_hi (
      .clk(clk), .rst(rst), .we(we_hi), .d(src[HALF_W-1:0]), .q(hi_q)
   );

   assign tb = {hi_q, lo_q};

   logic unused_src_hi;
   assign unused_src_hi = ^src[DATA_W-1:HALF_W];

endmodule

// File: rtl/spr_insn_decode.sv
module spr_insn_decode
   import spr_wr_pkg::*;
#(
   parameter int unsigned NUM_W = 10
) (
   input  logic [31:0]      insn,
   output logic             hit,
   output logic [4:0]       rs_idx,
   output logic [NUM_W-1:0] spr_num,
   output spr_tgt_e         tgt
);

   localparam int unsigned HALF = NUM_W / 2;

   generate
      if (NUM_W != 10) begin : g_bad_num
         $error("spr_insn_decode: register field is 10 bits wide");
      end
   endgenerate

   logic [NUM_W-1:0] field;

   assign field   = insn[20:11];
   assign rs_idx  = insn[25:21];
   // Halves are stored transposed; swap them back.
   assign spr_num = {field[HALF-1:0], field[NUM_W-1:HALF]};
   assign hit     = (insn[31:26] == 6'(OPC_PRIMARY)) && (insn[10:1] == 10'(OPC_EXT));
   assign tgt     = classify(spr_num);

   logic unused_rsvd;
   assign unused_rsvd = insn[0];

endmodule

// File: rtl/spr_priv_gate.sv
module spr_priv_gate
   import spr_wr_pkg::*;
#(
   parameter bit ENFORCE_PRIV = 1'b1
) (
   input  logic     valid,
   input  logic     hit,
   input  spr_tgt_e tgt,
   input  logic     sup,
   output logic     wr_xer,
   output logic     wr_lr,
   output logic     wr_ctr,
   output logic     wr_vrs,
   output logic     wr_tb_lo,
   output logic     wr_tb_hi,
   output logic     trap,
   output logic     unknown,
   output logic     advance
);

   logic live;
   logic allowed;

   assign live = valid && hit;

   generate
      if (ENFORCE_PRIV) begin : g_enforce
         assign allowed = !needs_supervisor(tgt) || sup;
      end else begin : g_open
         logic unused_sup;
         assign unused_sup = sup;
         assign allowed    = 1'b1;
      end
   endgenerate

   always_comb begin
      wr_xer   = 1'b0;
      wr_lr    = 1'b0;
      wr_ctr   = 1'b0;
      wr_vrs   = 1'b0;
      wr_tb_lo = 1'b0;
      wr_tb_hi = 1'b0;
      unknown  = 1'b0;
      trap     = live && !allowed;
      advance  = live && allowed;
      if (live && allowed) begin
         unique case (tgt)
            TGT_XER:    wr_xer   = 1'b1;
            TGT_LR:     wr_lr    = 1'b1;
            TGT_CTR:    wr_ctr   = 1'b1;
            TGT_VRSAVE: wr_vrs   = 1'b1;
            TGT_TB_LO:  wr_tb_lo = 1'b1;
            TGT_TB_HI:  wr_tb_hi = 1'b1;
            TGT_SINK:   ;
            TGT_NONE:   unknown  = 1'b1;
            default:    ;
         endcase
      end
   end

endmodule

// File: rtl/spr_write_unit.sv
module spr_write_unit
   import spr_wr_pkg::*;
#(
   parameter int unsigned DATA_W       = 64,
   parameter int unsigned WORD_W       = 32,
   parameter int unsigned NUM_W        = 10,
   parameter bit          ENFORCE_PRIV = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  logic [31:0]       insn_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic              sup_i,
   output logic [4:0]        rs_idx_o,
   output logic [WORD_W-1:0] xer_o,
   output logic [DATA_W-1:0] lr_o,
   output logic [DATA_W-1:0] ctr_o,
   output logic [WORD_W-1:0] vrsave_o,
   output logic [DATA_W-1:0] tbase_o,
   output logic              pc_adv_o,
   output logic              priv_trap_o,
   output logic              unimpl_o
);

   localparam int unsigned PAD_W = DATA_W - WORD_W;

   generate
      if (DATA_W != 2 * WORD_W) begin : g_bad_data
         $error("spr_write_unit: DATA_W must be twice WORD_W");
      end
      if (NUM_W != 10) begin : g_bad_num
         $error("spr_write_unit: NUM_W must be 10");
      end
   endgenerate

   logic             hit;
   logic [NUM_W-1:0] spr_num;
   spr_tgt_e         tgt;

   spr_insn_decode #(.NUM_W(NUM_W)) u_dec (
      .insn(insn_i), .hit(hit), .rs_idx(rs_idx_o), .spr_num(spr_num), .tgt(tgt)
   );

   logic wr_xer, wr_lr, wr_ctr, wr_vrs, wr_tb_lo, wr_tb_hi;
   logic trap_c, unknown_c, advance_c;

   spr_priv_gate #(.ENFORCE_PRIV(ENFORCE_PRIV)) u_gate (
      .valid(valid_i), .hit(hit), .tgt(tgt), .sup(sup_i),
      .wr_xer(wr_xer), .wr_lr(wr_lr), .wr_ctr(wr_ctr), .wr_vrs(wr_vrs),
      .wr_tb_lo(wr_tb_lo), .wr_tb_hi(wr_tb_hi),
      .trap(trap_c), .unknown(unknown_c), .advance(advance_c)
   );

   logic [WORD_W-1:0] ctr_q;

   spr_hold_reg #(.W(WORD_W)) u_xer (
      .clk(clk), .rst(rst), .we(wr_xer), .d(src_i[WORD_W-1:0]), .q(xer_o)
   );

   spr_hold_reg #(.W(DATA_W)) u_lr (
      .clk(clk), .rst(rst), .we(wr_lr), .d(src_i), .q(lr_o)
   );

   // Count register keeps only the low word; the upper half reads as zero.
   spr_hold_reg #(.W(WORD_W)) u_ctr (
      .clk(clk), .rst(rst), .we(wr_ctr), .d(src_i[WORD_W-1:0]), .q(ctr_q)
   );
   assign ctr_o = {{PAD_W{1'b0}}, ctr_q};

   spr_hold_reg #(.W(WORD_W)) u_vrs (
      .clk(clk), .rst(rst), .we(wr_vrs), .d(src_i[WORD_W-1:0]), .q(vrsave_o)
   );

   spr_timebase #(.DATA_W(DATA_W)) u_tb (
      .clk(clk), .rst(rst), .we_lo(wr_tb_lo), .we_hi(wr_tb_hi),
      .src(src_i), .tb(tbase_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_adv_o    <= 1'b0;
         priv_trap_o <= 1'b0;
         unimpl_o    <= 1'b0;
      end else begin
         pc_adv_o    <= advance_c;
         priv_trap_o <= trap_c;
         unimpl_o    <= unknown_c;
      end
   end

   logic unused_num;
   assign unused_num = ^spr_num;

endmodule

// File: rtl/spr_write_unit_chk.sv
module spr_write_unit_chk #(
   parameter int unsigned DATA_W       = 64,
   parameter int unsigned WORD_W       = 32,
   parameter int unsigned NUM_W        = 10,
   parameter bit          ENFORCE_PRIV = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              valid_i,
   input logic [31:0]       insn_i,
   input logic [DATA_W-1:0] src_i,
   input logic              sup_i,
   input logic [4:0]        rs_idx_o,
   input logic [WORD_W-1:0] xer_o,
   input logic [DATA_W-1:0] lr_o,
   input logic [DATA_W-1:0] ctr_o,
   input logic [WORD_W-1:0] vrsave_o,
   input logic [DATA_W-1:0] tbase_o,
   input logic              pc_adv_o,
   input logic              priv_trap_o,
   input logic              unimpl_o
);

   // R6
   trap_excl_chk: assert property (@(posedge clk) disable iff (rst)
      priv_trap_o |-> (!pc_adv_o && !unimpl_o));

   // R6
   trap_mode_chk: assert property (@(posedge clk) disable iff (rst)
      priv_trap_o |-> !$past(sup_i));

   // R6
   trap_hold_chk: assert property (@(posedge clk) disable iff (rst)
      priv_trap_o |-> ($stable(xer_o) && $stable(lr_o) && $stable(ctr_o)
                       && $stable(vrsave_o) && $stable(tbase_o)));

   // R8
   unimpl_adv_chk: assert property (@(posedge clk) disable iff (rst)
      unimpl_o |-> pc_adv_o);

   // R8
   unimpl_hold_chk: assert property (@(posedge clk) disable iff (rst)
      unimpl_o |-> ($stable(xer_o) && $stable(lr_o) && $stable(ctr_o)
                    && $stable(vrsave_o) && $stable(tbase_o)));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> ($stable(xer_o) && $stable(lr_o) && $stable(ctr_o)
                    && $stable(vrsave_o) && $stable(tbase_o)
                    && !pc_adv_o && !priv_trap_o && !unimpl_o));

   // R4
   ctr_zext_chk: assert property (@(posedge clk) disable iff (rst)
      ctr_o[DATA_W-1:WORD_W] == '0);

   // R2
   rs_idx_chk: assert property (@(posedge clk) disable iff (rst)
      rs_idx_o == insn_i[25:21]);

   logic unused_in;
   assign unused_in = ^{src_i, insn_i[31:26], insn_i[20:0]};

endmodule

bind spr_write_unit spr_write_unit_chk #(
   .DATA_W(DATA_W), .WORD_W(WORD_W), .NUM_W(NUM_W), .ENFORCE_PRIV(ENFORCE_PRIV)
) u_chk (.*);

// File: tb/spr_write_unit_tb.sv
module spr_write_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam int MAX_CYCLES = 200000;

   logic        clk = 1'b0;
   logic        rst;
   logic        valid_i;
   logic [31:0] insn_i;
   logic [63:0] src_i;
   logic        sup_i;
   logic [4:0]  rs_idx_o;
   logic [31:0] xer_o;
   logic [63:0] lr_o;
   logic [63:0] ctr_o;
   logic [31:0] vrsave_o;
   logic [63:0] tbase_o;
   logic        pc_adv_o;
   logic        priv_trap_o;
   logic        unimpl_o;

   spr_write_unit u_dut (
      .clk(clk), .rst(rst), .valid_i(valid_i), .insn_i(insn_i), .src_i(src_i),
      .sup_i(sup_i), .rs_idx_o(rs_idx_o), .xer_o(xer_o), .lr_o(lr_o),
      .ctr_o(ctr_o), .vrsave_o(vrsave_o), .tbase_o(tbase_o),
      .pc_adv_o(pc_adv_o), .priv_trap_o(priv_trap_o), .unimpl_o(unimpl_o)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   // Model state
   logic [31:0] m_xer;
   logic [63:0] m_lr, m_ctr, m_tb;
   logic [31:0] m_vrs;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_xer = '0; m_lr = '0; m_ctr = '0; m_tb = '0; m_vrs = '0;
   endtask

   task automatic check_state(input string req);
      chk(req, "xer", 64'(xer_o), 64'(m_xer));
      chk(req, "lr", lr_o, m_lr);
      chk(req, "ctr", ctr_o, m_ctr);
      chk(req, "vrsave", 64'(vrsave_o), 64'(m_vrs));
      chk(req, "tbase", tbase_o, m_tb);
   endtask

   task automatic check_pulses(input string req, input logic adv,
                               input logic trp, input logic unk);
      chk(req, "pc_adv", 64'(pc_adv_o), 64'(adv));
      chk(req, "priv_trap", 64'(priv_trap_o), 64'(trp));
      chk(req, "unimpl", 64'(unimpl_o), 64'(unk));
   endtask

   function automatic logic [63:0] mix(input int k);
      logic [31:0] a, b;
      a = 32'(k) * 32'h9E37_79B9 ^ 32'hC0DE_0001;
      b = ~(32'(k) * 32'h85EB_CA6B) ^ 32'h5A5A_0F0F;
      return {a, b};
   endfunction

   function automatic logic [31:0] mk_insn(input logic [5:0] opc, input logic [4:0] rs,
                                           input logic [9:0] num, input logic [9:0] xo,
                                           input logic rsvd);
      // field stores the two halves of the number swapped
      return {opc, rs, num[4:0], num[9:5], xo, rsvd};
   endfunction

   // One instruction: valid for one cycle, then an idle cycle.
   // recog=0 means the word is not the instruction at all.
   task automatic run_op(input logic [31:0] insn, input logic [63:0] src,
                         input logic sup, input logic recog);
      logic [9:0] f, n;
      logic priv, sink, known, trp, adv, unk;
      string req;
      f = insn[20:11];
      n = {f[4:0], f[9:5]};
      sink  = (n >= 272 && n <= 275) || n == 1008 || n == 1009 || n == 18 || n == 19;
      priv  = sink || n == 284 || n == 285;
      known = priv || n == 1 || n == 8 || n == 9 || n == 256;
      trp = recog && priv && !sup;
      adv = recog && !trp;
      unk = recog && !known;
      @(negedge clk);
      valid_i = 1'b1; insn_i = insn; src_i = src; sup_i = sup;
      #1;
      chk("R2", "rs_idx", 64'(rs_idx_o), 64'(insn[25:21]));
      if (recog && !trp) begin
         case (n)
            10'd1:   m_xer = src[31:0];
            10'd8:   m_lr  = src;
            10'd9:   m_ctr = {32'h0, src[31:0]};
            10'd256: m_vrs = src[31:0];
            10'd284: m_tb  = {m_tb[63:32], src[31:0]};
            10'd285: m_tb  = {src[31:0], m_tb[31:0]};
            default: ;
         endcase
      end
      if (!recog)                      req = "R1";
      else if (trp)                    req = "R6";
      else if (sink)                   req = "R7";
      else if (!known)                 req = "R8";
      else if (n == 1 || n == 8)       req = "R3";
      else if (n == 9 || n == 256)     req = "R4";
      else                             req = "R5";
      @(negedge clk);
      valid_i = 1'b0;
      check_state(req);
      check_pulses(req, adv, trp, unk);
      @(negedge clk);
      check_state("R9");
      check_pulses("R9", 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      while (!done && cycles < MAX_CYCLES) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; valid_i = 1'b0; insn_i = '0; src_i = '0; sup_i = 1'b0;
      model_reset();
      repeat (3) @(negedge clk);
      // Reset state, R10
      check_state("R10");
      check_pulses("R10", 1'b0, 1'b0, 1'b0);
      rst = 1'b0;

      // Basic writes, supervisor and problem state
      run_op(mk_insn(6'd31, 5'd3, 10'd8, 10'd467, 1'b0), 64'hFEDC_BA98_7654_3210, 1'b0, 1'b1);
      run_op(mk_insn(6'd31, 5'd4, 10'd9, 10'd467, 1'b0), 64'hFFFF_FFFF_8000_0001, 1'b0, 1'b1);
      run_op(mk_insn(6'd31, 5'd5, 10'd1, 10'd467, 1'b0), 64'h1111_2222_3333_4444, 1'b0, 1'b1);
      run_op(mk_insn(6'd31, 5'd6, 10'd256, 10'd467, 1'b0), 64'hAAAA_BBBB_CCCC_DDDD, 1'b1, 1'b1);
      // Time base halves, R5
      run_op(mk_insn(6'd31, 5'd7, 10'd284, 10'd467, 1'b0), 64'h9999_9999_0123_4567, 1'b1, 1'b1);
      run_op(mk_insn(6'd31, 5'd8, 10'd285, 10'd467, 1'b0), 64'h7777_7777_89AB_CDEF, 1'b1, 1'b1);
      run_op(mk_insn(6'd31, 5'd9, 10'd284, 10'd467, 1'b0), 64'h0000_0000_FFFF_0000, 1'b1, 1'b1);
      // Time base in problem state traps, R6
      run_op(mk_insn(6'd31, 5'd9, 10'd285, 10'd467, 1'b0), 64'h1234_5678_1234_5678, 1'b0, 1'b1);

      // Not the instruction, R1
      run_op(mk_insn(6'd30, 5'd1, 10'd8, 10'd467, 1'b0), 64'h0BAD_0BAD_0BAD_0BAD, 1'b1, 1'b0);
      run_op(mk_insn(6'd31, 5'd1, 10'd8, 10'd466, 1'b0), 64'h0BAD_0BAD_0BAD_0BAD, 1'b1, 1'b0);
      run_op(mk_insn(6'd31, 5'd1, 10'd9, 10'd339, 1'b0), 64'h0BAD_0BAD_0BAD_0BAD, 1'b1, 1'b0);
      // Reserved bit ignored, R1
      run_op(mk_insn(6'd31, 5'd2, 10'd8, 10'd467, 1'b1), 64'h0102_0304_0506_0708, 1'b0, 1'b1);

      // Full sweep of the field in both modes (R2, R3..R8)
      for (int s = 0; s < 2; s++) begin
         for (int f = 0; f < 1024; f++) begin
            logic [9:0] fv;
            logic [31:0] w;
            fv = 10'(f);
            w = {6'd31, 5'(f), fv, 10'd467, 1'b0};
            run_op(w, mix(f + 1024 * s), 1'(s), 1'b1);
         end
      end

      // Reset after activity clears everything, R10
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      model_reset();
      check_state("R10");
      check_pulses("R10", 1'b0, 1'b0, 1'b0);
      rst = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule